// File: doc/BRIEF.md
# Rejected Interrupt Bitmap Resender

This block remembers which interrupt sources were turned away by the interrupt presentation logic, and replays them later on request. Each reject carries a global interrupt number. The block subtracts a programmable base to get a local source number, and marks that source in a bitmap of 32 words of 64 bits. A 32-bit summary, with one bit per word, shows which words may hold marks.

When a resend strobe arrives, the block walks the summary from low to high and skips empty words without spending a cycle on each of their bits. Inside each word it issues one send request per marked source, from the lowest bit upward, and clears each mark as it goes. Every request is a forced send: the dispatcher delivers it without looking at any stored pending or queued state. The dispatcher accepts a request with a valid/ready handshake, and the scan waits while ready is low.

Top module: `rejbm_resender`

## Requirements
- R1: The local source is `rej_irq - irq_base`. Its bits [10:6] select the word and bits [5:0] select the bit within that word. `send_src` reports the local number word*64+bit.
- R2: An in-range reject marks its source and the summary bit of its word. Rejecting the same source twice before a resend produces only one send.
- R3: A resend while the summary is all zero has no effect: `busy` stays low and no request appears.
- R4: A resend with a non-empty summary raises `busy` in the following cycle. `busy` stays high until the scan ends. A resend strobe while `busy` is high is ignored.
- R5: A scan issues each marked source exactly once, in ascending word order and ascending bit order within a word, and clears each mark it issues.
- R6: Reset clears every mark and the summary, so a resend right after reset issues nothing.
- R7: A reject is ignored if `rej_irq < irq_base` or if the local number is 2048 or more. The cycle after such a reject, `rej_err` is high for exactly one cycle. An in-range reject leaves `rej_err` low.
- R8: A reject that arrives during a scan is recorded. If it falls in a word already passed, or at a bit at or below the current position in the active word, it is sent on the next resend. If it falls ahead of the scan position, it is sent in the current scan.
- R9: At most one request is issued per cycle, and it transfers when `send_valid` and `send_ready` are both high. While `send_valid` is high and `send_ready` is low, `send_src` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_base | input | IRQ_W | Global number of local source 0 |
| rej_valid | input | 1 | Reject strobe |
| rej_irq | input | IRQ_W | Global interrupt number being rejected |
| rej_err | output | 1 | One-cycle pulse after an out-of-range reject |
| resend | input | 1 | Start a replay scan |
| busy | output | 1 | Scan in progress |
| send_valid | output | 1 | Forced send request valid |
| send_src | output | SRC_W | Local source number of the request |
| send_ready | input | 1 | Dispatcher accepts the request |

## Verification
A wrong mark or summary bit shows up at the ports only on the next resend. It appears as a missing, duplicated or out-of-order `send_src`, or as a scan that never raises `busy`. For this reason every stimulus phase ends in a full scan, which is compared against an independent model of marked sources. A wrong scan pointer shows up within a single cycle of the request stream, as a source below an earlier one. A stall bug shows up as `send_src` changing while ready is held low.

// File: rtl/rbr_pkg.sv
package rbr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIND = 2'd1,
        ST_SEND = 2'd2
    } rbr_state_e;
endpackage

// File: rtl/rbr_first_set.sv
// Lowest set bit of vec at an index >= start; start == N means none.
module rbr_first_set #(
    parameter int N  = 64,
    parameter int SW = $clog2(N) + 1,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    input  logic [SW-1:0] start,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i] && (i >= int'(start))) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rbr_reject_map.sv
// Converts a global interrupt number into a local source and range flag.
module rbr_reject_map #(
    parameter int IRQ_W = 24,
    parameter int SRC_W = 11,
    parameter int TOTAL = 2048
) (
    input  logic [IRQ_W-1:0] irq,
    input  logic [IRQ_W-1:0] base,
    output logic             in_range,
    output logic [SRC_W-1:0] src
);
    logic [IRQ_W-1:0] diff;

    always_comb begin
        diff     = irq - base;
        in_range = (irq >= base) && (diff < IRQ_W'(TOTAL));
        src      = diff[SRC_W-1:0];
    end
endmodule

// File: rtl/rejbm_resender.sv
module rejbm_resender
    import rbr_pkg::*;
#(
    parameter int WORDS = 32,
    parameter int WBITS = 64,
    parameter int IRQ_W = 24,
    localparam int WORD_W = $clog2(WORDS),
    localparam int BIT_W  = $clog2(WBITS),
    localparam int SRC_W  = WORD_W + BIT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] irq_base,
    input  logic             rej_valid,
    input  logic [IRQ_W-1:0] rej_irq,
    output logic             rej_err,
    input  logic             resend,
    output logic             busy,
    output logic             send_valid,
    output logic [SRC_W-1:0] send_src,
    input  logic             send_ready
);
    localparam int TOTAL = WORDS * WBITS;

    typedef struct packed {
        rbr_state_e                   st;
        logic [WORD_W-1:0]            wptr;
        logic [WORD_W-1:0]            cur_w;
        logic [BIT_W-1:0]             cand;
        logic [WORDS-1:0]             sum;
        logic [WORDS-1:0][WBITS-1:0]  bits;
        logic                         err;
    } regs_t;

    regs_t q, d;

    // reject decode
    logic             rj_ok;
    logic [SRC_W-1:0] rj_src;

    rbr_reject_map #(
        .IRQ_W (IRQ_W),
        .SRC_W (SRC_W),
        .TOTAL (TOTAL)
    ) u_map (
        .irq      (rej_irq),
        .base     (irq_base),
        .in_range (rj_ok),
        .src      (rj_src)
    );

    // next marked word at or after the scan pointer
    logic              s_found;
    logic [WORD_W-1:0] s_idx;

    rbr_first_set #(.N(WORDS)) u_sum_find (
        .vec   (q.sum),
        .start ({1'b0, q.wptr}),
        .found (s_found),
        .idx   (s_idx)
    );

    // next marked bit inside the selected word
    logic [WORD_W-1:0] sel_w;
    logic [BIT_W:0]    b_start;
    logic              b_found;
    logic [BIT_W-1:0]  b_idx;

    always_comb begin
        if (q.st == ST_FIND) begin
            sel_w   = s_idx;
            b_start = '0;
        end else begin
            sel_w   = q.cur_w;
            b_start = {1'b0, q.cand} + 1'b1;
        end
    end

    rbr_first_set #(.N(WBITS)) u_bit_find (
        .vec   (q.bits[sel_w]),
        .start (b_start),
        .found (b_found),
        .idx   (b_idx)
    );

    always_comb begin
        d     = q;
        d.err = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (resend && (q.sum != '0)) begin
                    d.st   = ST_FIND;
                    d.wptr = '0;
                end
            end
            ST_FIND: begin
                if (!s_found) begin
                    d.st = ST_IDLE;
                end else begin
                    d.sum[s_idx] = 1'b0;
                    d.cur_w      = s_idx;
                    if (b_found) begin
                        d.cand = b_idx;
                        d.st   = ST_SEND;
                    end else if (s_idx == WORD_W'(WORDS - 1)) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.wptr = s_idx + 1'b1;
                    end
                end
            end
            ST_SEND: begin
                if (send_ready) begin
                    d.bits[q.cur_w][q.cand] = 1'b0;
                    if (b_found) begin
                        d.cand = b_idx;
                    end else if (q.cur_w == WORD_W'(WORDS - 1)) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.wptr = q.cur_w + 1'b1;
                        d.st   = ST_FIND;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        // a new reject takes priority over a clear in the same cycle
        if (rej_valid) begin
            if (rj_ok) begin
                d.bits[rj_src[SRC_W-1:BIT_W]][rj_src[BIT_W-1:0]] = 1'b1;
                d.sum[rj_src[SRC_W-1:BIT_W]]                     = 1'b1;
            end else begin
                d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign send_valid = (q.st == ST_SEND);
    assign send_src   = {q.cur_w, q.cand};
    assign busy       = (q.st != ST_IDLE);
    assign rej_err    = q.err;
endmodule

// File: rtl/rbr_checks.sv
module rbr_checks #(
    parameter int WORDS = 32,
    parameter int WBITS = 64,
    parameter int IRQ_W = 24,
    parameter int SRC_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IRQ_W-1:0] irq_base,
    input logic             rej_valid,
    input logic [IRQ_W-1:0] rej_irq,
    input logic             rej_err,
    input logic             resend,
    input logic             busy,
    input logic             send_valid,
    input logic [SRC_W-1:0] send_src,
    input logic             send_ready,
    input logic [WORDS-1:0] summary
);
    localparam int TOTAL = WORDS * WBITS;

    logic bad_rej;
    assign bad_rej = rej_valid &&
        ((rej_irq < irq_base) || ((rej_irq - irq_base) >= IRQ_W'(TOTAL)));

    // R9: a stalled request keeps its source
    p_hold_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        send_valid && !send_ready |=> send_valid && $stable(send_src));

    // R3: no request outside a scan
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !send_valid);

    // R3: an empty resend does not start a scan
    p_empty_resend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && resend && (summary == '0) && !rej_valid |=> !busy);

    // R4: a resend with marks starts a scan next cycle
    p_busy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && resend && (summary != '0) |=> busy);

    // R7: out-of-range reject flags an error
    p_err_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bad_rej |=> rej_err);

    // R7: in-range or absent reject leaves the flag low
    p_no_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_rej |=> !rej_err);

    // R2: an accepted reject leaves the summary non-empty
    p_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid && !bad_rej |=> summary != '0);
endmodule

bind rejbm_resender rbr_checks #(
    .WORDS (WORDS),
    .WBITS (WBITS),
    .IRQ_W (IRQ_W),
    .SRC_W (SRC_W)
) u_rbr_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_base   (irq_base),
    .rej_valid  (rej_valid),
    .rej_irq    (rej_irq),
    .rej_err    (rej_err),
    .resend     (resend),
    .busy       (busy),
    .send_valid (send_valid),
    .send_src   (send_src),
    .send_ready (send_ready),
    .summary    (q.sum)
);

// File: tb/test_rejbm_resender.sv
module test_rejbm_resender;
    localparam int IRQ_W = 24;
    localparam int SRC_W = 11;
    localparam int TOTAL = 2048;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IRQ_W-1:0] irq_base = '0;
    logic             rej_valid = 1'b0;
    logic [IRQ_W-1:0] rej_irq = '0;
    logic             rej_err;
    logic             resend = 1'b0;
    logic             busy;
    logic             send_valid;
    logic [SRC_W-1:0] send_src;
    logic             send_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    bit mdl [0:TOTAL-1];
    int got [$];

    always #10 clk = ~clk;

    rejbm_resender i_rejbm_resender (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_base   (irq_base),
        .rej_valid  (rej_valid),
        .rej_irq    (rej_irq),
        .rej_err    (rej_err),
        .resend     (resend),
        .busy       (busy),
        .send_valid (send_valid),
        .send_src   (send_src),
        .send_ready (send_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lowest_marked();
        for (int i = 0; i < TOTAL; i++) if (mdl[i]) return i;
        return -1;
    endfunction

    function automatic int count_marked();
        int n = 0;
        for (int i = 0; i < TOTAL; i++) if (mdl[i]) n++;
        return n;
    endfunction

    task automatic reject_at(input logic [IRQ_W-1:0] irq, input bit exp_err, input string req);
        @(negedge clk);
        rej_valid = 1'b1;
        rej_irq   = irq;
        @(negedge clk);
        rej_valid = 1'b0;
        chk(rej_err == exp_err, req, int'(rej_err), int'(exp_err));
    endtask

    task automatic pulse_resend();
        @(negedge clk);
        resend = 1'b1;
        @(negedge clk);
        resend = 1'b0;
    endtask

    // drives ready at random, checks each accepted request against the model
    task automatic run_scan(input int pct, input string req);
        bit stalled = 1'b0;
        int last = 0;
        int exp;
        for (int cyc = 0; cyc < 20000; cyc++) begin
            if (!busy && !send_valid) break;
            @(negedge clk);
            send_ready = (($urandom % 100) < pct);
            #1;
            if (stalled) chk(send_valid && (int'(send_src) == last), "R9", int'(send_src), last);
            stalled = 1'b0;
            if (send_valid) begin
                if (send_ready) begin
                    exp = lowest_marked();
                    chk(int'(send_src) == exp, req, int'(send_src), exp);
                    if (exp >= 0) mdl[exp] = 1'b0;
                end else begin
                    stalled = 1'b1;
                    last    = int'(send_src);
                end
            end
        end
        @(negedge clk);
        send_ready = 1'b0;
        chk(count_marked() == 0, "R5", count_marked(), 0);
        chk(!busy, "R4", int'(busy), 0);
    endtask

    task automatic collect_all();
        got.delete();
        for (int cyc = 0; cyc < 2000; cyc++) begin
            @(negedge clk);
            send_ready = 1'b1;
            #1;
            if (send_valid) got.push_back(int'(send_src));
            if (!busy) break;
        end
        send_ready = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < TOTAL; i++) mdl[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: reset state
        chk(!busy && !send_valid && !rej_err, "R6", int'(busy), 0);

        // R3: empty resend does nothing
        pulse_resend();
        for (int k = 0; k < 4; k++) begin
            chk(!busy && !send_valid, "R3", int'(busy), 0);
            @(negedge clk);
        end

        // R1/R5: boundary sources with a non-zero base, plus a duplicate (R2)
        irq_base = 24'h100;
        foreach (mdl[i]) mdl[i] = 1'b0;
        mdl[0] = 1'b1; mdl[63] = 1'b1; mdl[64] = 1'b1; mdl[2047] = 1'b1;
        reject_at(24'h100 + 2047, 1'b0, "R1");
        reject_at(24'h100 + 64,   1'b0, "R1");
        reject_at(24'h100 + 0,    1'b0, "R1");
        reject_at(24'h100 + 63,   1'b0, "R1");
        reject_at(24'h100 + 63,   1'b0, "R2");
        // R7: out of range on both sides
        reject_at(24'h100 + 2048, 1'b1, "R7");
        reject_at(24'h0FF,        1'b1, "R7");
        @(negedge clk);
        chk(!rej_err, "R7", int'(rej_err), 0);
        pulse_resend();
        chk(busy, "R4", int'(busy), 1);
        run_scan(100, "R5");

        // random rounds
        for (int r = 0; r < 8; r++) begin
            int n;
            int src;
            irq_base = IRQ_W'($urandom % 100000);
            n = 1 + ($urandom % 40);
            for (int k = 0; k < n; k++) begin
                src = (r % 2 == 0) ? int'($urandom % TOTAL) : int'(($urandom % 3) * 64 + ($urandom % 64));
                mdl[src] = 1'b1;
                reject_at(irq_base + IRQ_W'(src), 1'b0, "R1");
            end
            reject_at(irq_base + IRQ_W'(TOTAL + ($urandom % 500)), 1'b1, "R7");
            pulse_resend();
            chk(busy, "R4", int'(busy), 1);
            // R4: a second resend while busy is ignored
            pulse_resend();
            run_scan(30 + r * 10, "R5");
        end

        // R8/R9: rejects arriving during a stalled scan
        irq_base = '0;
        reject_at(24'd5,   1'b0, "R2");
        reject_at(24'd200, 1'b0, "R2");
        send_ready = 1'b0;
        pulse_resend();
        for (int k = 0; k < 10; k++) begin
            if (send_valid) break;
            @(negedge clk);
        end
        chk(send_valid && send_src == 11'd5, "R9", int'(send_src), 5);
        reject_at(24'd10,  1'b0, "R8");
        reject_at(24'd1,   1'b0, "R8");
        reject_at(24'd130, 1'b0, "R8");
        chk(send_valid && send_src == 11'd5, "R9", int'(send_src), 5);
        collect_all();
        chk(got.size() == 4, "R8", got.size(), 4);
        if (got.size() == 4) begin
            chk(got[0] == 5,   "R8", got[0], 5);
            chk(got[1] == 10,  "R8", got[1], 10);
            chk(got[2] == 130, "R8", got[2], 130);
            chk(got[3] == 200, "R8", got[3], 200);
        end
        pulse_resend();
        collect_all();
        chk(got.size() == 1, "R8", got.size(), 1);
        if (got.size() == 1) chk(got[0] == 1, "R8", got[0], 1);

        // R6: reset discards marks
        reject_at(24'd77,   1'b0, "R2");
        reject_at(24'd1500, 1'b0, "R2");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        pulse_resend();
        for (int k = 0; k < 4; k++) begin
            chk(!busy && !send_valid, "R6", int'(busy), 0);
            @(negedge clk);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule